// File: doc/BRIEF.md
# Watchdog Timer with Grace Window and Wakeup

This block is a watchdog that runs on its own watchdog clock. Once it is enabled, an up-counter advances on every clock. When the counter reaches the interval that a three-bit select chooses, a sticky timeout flag is set, and an interrupt request follows if interrupts are enabled. A grace window of fixed length then starts. If software writes the restart strobe inside that window, the counter is cleared and nothing further happens.

If the window runs out without a restart, the block drives a CPU reset pulse of fixed length. It also sets a sticky reset-cause flag, which keeps its value through that pulse so that software can read the cause afterwards. When the pulse ends, the enable bit drops to 0. When the power-down input is high and wakeup is enabled, the expiry of the window raises a wakeup request instead of the reset. That request stays high until power-down is released.

Software reaches the block through a write strobe that carries the configuration fields, the restart strobe and the write-one-to-clear bits. The configuration and the flags are read back on dedicated outputs. The synchronous power-on reset clears every register, including the reset-cause flag.

Top module: `wdg_top`

## Requirements
- R1: After power-on reset, every flag, the configuration readback, the restart-busy indication, the interrupt, the CPU reset and the wakeup outputs are 0.
- R2: After a write sets enable with select code s (0 to 7), the timeout flag rises exactly 2^(4+2s) watchdog clocks after the edge that takes the write.
- R3: The interrupt output is high only while both the timeout flag and the interrupt-enable bit are high.
- R4: The timeout flag and the reset-cause flag stay set until a write carries a 1 in their clear bit. Such a write clears the flag.
- R5: A write with the restart bit sets restart-busy for exactly one clock. On the next edge the counter returns to 0, so the next timeout comes one full interval plus one clock after the write edge.
- R6: A restart written inside the grace window prevents the CPU reset.
- R7: Without a restart, the CPU reset rises 1024 clocks after the edge that set the timeout flag.
- R8: The CPU reset stays high for exactly 63 clocks, and the reset-cause flag is set on the edge where the reset rises.
- R9: When the reset pulse ends, the enable bit reads 0 and the counter stays stopped.
- R10: When the window expires while power-down and wakeup-enable are both high, the wakeup request goes high and no CPU reset is issued. The request holds while power-down stays high and clears on the first edge where it is low.
- R11: A write that clears enable or changes the select code clears the counter and cancels a running grace window.
- R12: While enable is 0, the counter does not advance and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value, loaded on write |
| ctl_sel | input | 3 | Interval select code, loaded on write |
| ctl_irq_en | input | 1 | Interrupt enable, loaded on write |
| ctl_wake_en | input | 1 | Wakeup enable, loaded on write |
| ctl_restart | input | 1 | Restart strobe, acts when written as 1 |
| ctl_clr_tof | input | 1 | Write 1 to clear the timeout flag |
| ctl_clr_rstf | input | 1 | Write 1 to clear the reset-cause flag |
| pwr_down | input | 1 | Chip is in power-down |
| cfg_enable | output | 1 | Enable readback |
| cfg_sel | output | 3 | Select readback |
| cfg_irq_en | output | 1 | Interrupt enable readback |
| cfg_wake_en | output | 1 | Wakeup enable readback |
| restart_busy | output | 1 | Restart in progress |
| tof_flag | output | 1 | Sticky timeout flag |
| rstf_flag | output | 1 | Sticky reset-cause flag |
| irq | output | 1 | Interrupt request |
| cpu_rst | output | 1 | CPU reset pulse |
| wake_req | output | 1 | Wakeup request level |

## Verification
The assertions assume that software does not write the clear bits or a restart while the reset pulse is active, because the CPU is held in reset during that time. They also assume that power-down is changed only between clock edges. The stimulus keeps to these rules. Every write happens outside the 63-clock pulse, every input is driven at the falling edge, and power-down is raised before wakeup is enabled and dropped together with a disabling write. Restart offsets and select codes are drawn at random, but only from ranges where the restart lands inside the grace window and away from a counter rollover.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W      = 18;
    localparam int SEL_W      = 3;
    localparam int NUM_SEL    = 1 << SEL_W;
    localparam int EXP_BASE   = 4;
    localparam int EXP_STEP   = 2;
    localparam int GRACE_CLKS = 1024;
    localparam int PULSE_CLKS = 63;

    typedef struct packed {
        logic             enable;
        logic [SEL_W-1:0] sel;
        logic             irq_en;
        logic             wake_en;
    } cfg_t;

    typedef struct packed {
        logic we;
        cfg_t cfg;
        logic restart;
        logic clr_tof;
        logic clr_rstf;
    } ctl_req_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GRACE = 2'd1,
        PH_PULSE = 2'd2
    } phase_e;

    // terminal count (interval minus one) for one select code
    function automatic logic [31:0] interval_last(input int code);
        return (32'd1 << (EXP_BASE + EXP_STEP * code)) - 32'd1;
    endfunction

endpackage

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             clear,
    output logic             timeout
);

    logic [CW-1:0] last_tab [NUM_SEL];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_sel;
    logic          at_last;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tab
        assign last_tab[g] = CW'(interval_last(g));
    end

    assign last_sel = last_tab[sel];
    assign at_last  = (cnt_q == last_sel);
    assign timeout  = en && !clear && at_last;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (en) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdg_seq.sv
module wdg_seq
    import wdg_pkg::*;
#(
    parameter int GRACE_N = GRACE_CLKS,
    parameter int PULSE_N = PULSE_CLKS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   timeout,
    input  logic   cancel,
    input  logic   pwr_down,
    input  logic   wake_en,
    output phase_e phase,
    output logic   wake_fire,
    output logic   pulse_start,
    output logic   pulse_end
);

    localparam int GW = $clog2(GRACE_N);
    localparam int PW = $clog2(PULSE_N);
    localparam logic [GW-1:0] G_LAST = GW'(GRACE_N - 1);
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_N - 1);

    phase_e        ph_q;
    logic [GW-1:0] g_q;
    logic [PW-1:0] p_q;
    logic          win_end;
    logic          wake_path;

    assign wake_path   = pwr_down && wake_en;
    assign win_end     = (ph_q == PH_GRACE) && !cancel && (g_q == G_LAST);
    assign wake_fire   = win_end && wake_path;
    assign pulse_start = win_end && !wake_path;
    assign pulse_end   = (ph_q == PH_PULSE) && (p_q == P_LAST);
    assign phase       = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            g_q  <= '0;
            p_q  <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (timeout && !cancel) begin
                        ph_q <= PH_GRACE;
                        g_q  <= '0;
                    end
                end
                PH_GRACE: begin
                    if (cancel) begin
                        ph_q <= PH_IDLE;
                    end else if (g_q == G_LAST) begin
                        ph_q <= wake_path ? PH_IDLE : PH_PULSE;
                        p_q  <= '0;
                    end else begin
                        g_q <= g_q + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (p_q == P_LAST) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        p_q <= p_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_req_t req,
    input  logic     timeout,
    input  logic     wake_fire,
    input  logic     pulse_start,
    input  logic     pulse_end,
    input  logic     pwr_down,
    output cfg_t     cfg,
    output logic     cfg_change,
    output logic     restart_pend,
    output logic     tof,
    output logic     rstf,
    output logic     wake
);

    cfg_t cfg_q;
    logic pend_q;
    logic tof_q;
    logic rstf_q;
    logic wake_q;

    assign cfg_change   = req.we && (!req.cfg.enable || (req.cfg.sel != cfg_q.sel));
    assign cfg          = cfg_q;
    assign restart_pend = pend_q;
    assign tof          = tof_q;
    assign rstf         = rstf_q;
    assign wake         = wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            pend_q <= 1'b0;
            tof_q  <= 1'b0;
            rstf_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (req.we) begin
                cfg_q <= req.cfg;
            end
            if (pulse_end) begin
                cfg_q.enable <= 1'b0;
            end

            pend_q <= req.we && req.restart;

            if (timeout) begin
                tof_q <= 1'b1;
            end else if (req.we && req.clr_tof) begin
                tof_q <= 1'b0;
            end

            if (pulse_start) begin
                rstf_q <= 1'b1;
            end else if (req.we && req.clr_rstf) begin
                rstf_q <= 1'b0;
            end

            if (wake_fire) begin
                wake_q <= 1'b1;
            end else if (!pwr_down) begin
                wake_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CW      = CNT_W,
    parameter int GRACE_N = GRACE_CLKS,
    parameter int PULSE_N = PULSE_CLKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic [SEL_W-1:0] ctl_sel,
    input  logic             ctl_irq_en,
    input  logic             ctl_wake_en,
    input  logic             ctl_restart,
    input  logic             ctl_clr_tof,
    input  logic             ctl_clr_rstf,
    input  logic             pwr_down,
    output logic             cfg_enable,
    output logic [SEL_W-1:0] cfg_sel,
    output logic             cfg_irq_en,
    output logic             cfg_wake_en,
    output logic             restart_busy,
    output logic             tof_flag,
    output logic             rstf_flag,
    output logic             irq,
    output logic             cpu_rst,
    output logic             wake_req
);

    ctl_req_t req;
    cfg_t     cfg;
    phase_e   phase;
    logic     cfg_change;
    logic     restart_pend;
    logic     timeout;
    logic     wake_fire;
    logic     pulse_start;
    logic     pulse_end;
    logic     hold;
    logic     cancel;

    always_comb begin
        req             = '0;
        req.we          = ctl_we;
        req.cfg.enable  = ctl_enable;
        req.cfg.sel     = ctl_sel;
        req.cfg.irq_en  = ctl_irq_en;
        req.cfg.wake_en = ctl_wake_en;
        req.restart     = ctl_restart;
        req.clr_tof     = ctl_clr_tof;
        req.clr_rstf    = ctl_clr_rstf;
    end

    assign hold   = (phase == PH_PULSE);
    assign cancel = restart_pend || cfg_change;

    wdg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .timeout     (timeout),
        .wake_fire   (wake_fire),
        .pulse_start (pulse_start),
        .pulse_end   (pulse_end),
        .pwr_down    (pwr_down),
        .cfg         (cfg),
        .cfg_change  (cfg_change),
        .restart_pend(restart_pend),
        .tof         (tof_flag),
        .rstf        (rstf_flag),
        .wake        (wake_req)
    );

    wdg_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg.enable),
        .sel    (cfg.sel),
        .clear  (hold || cancel),
        .timeout(timeout)
    );

    wdg_seq #(.GRACE_N(GRACE_N), .PULSE_N(PULSE_N)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .timeout    (timeout),
        .cancel     (cancel),
        .pwr_down   (pwr_down),
        .wake_en    (cfg.wake_en),
        .phase      (phase),
        .wake_fire  (wake_fire),
        .pulse_start(pulse_start),
        .pulse_end  (pulse_end)
    );

    assign cfg_enable   = cfg.enable;
    assign cfg_sel      = cfg.sel;
    assign cfg_irq_en   = cfg.irq_en;
    assign cfg_wake_en  = cfg.wake_en;
    assign restart_busy = restart_pend;
    assign irq          = tof_flag && cfg.irq_en;
    assign cpu_rst      = hold;

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
    parameter int PULSE_N = 63
) (
    input logic clk,
    input logic rst,
    input logic ctl_we,
    input logic ctl_restart,
    input logic ctl_clr_tof,
    input logic ctl_clr_rstf,
    input logic pwr_down,
    input logic tof_flag,
    input logic rstf_flag,
    input logic irq,
    input logic cpu_rst,
    input logic wake_req,
    input logic cfg_enable,
    input logic restart_busy
);

    localparam int RW = $clog2(PULSE_N + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !cpu_rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R3
    irq_needs_tof_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> tof_flag);

    // R4
    tof_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tof_flag && !(ctl_we && ctl_clr_tof) |=> tof_flag);

    // R4
    rstf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rstf_flag && !(ctl_we && ctl_clr_rstf) |=> rstf_flag);

    // R5
    busy_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        restart_busy && !(ctl_we && ctl_restart) |=> !restart_busy);

    // R8
    cause_at_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst) |-> rstf_flag);

    // R8
    pulse_not_long_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rst |-> (int'(run_q) < PULSE_N));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> (int'(run_q) == PULSE_N));

    // R9
    off_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> !cfg_enable);

    // R10
    wake_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> !cpu_rst);

    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req && pwr_down |=> wake_req);

    // R10
    wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |=> !wake_req);

endmodule

bind wdg_top wdg_chk #(.PULSE_N(PULSE_N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .ctl_restart (ctl_restart),
    .ctl_clr_tof (ctl_clr_tof),
    .ctl_clr_rstf(ctl_clr_rstf),
    .pwr_down    (pwr_down),
    .tof_flag    (tof_flag),
    .rstf_flag   (rstf_flag),
    .irq         (irq),
    .cpu_rst     (cpu_rst),
    .wake_req    (wake_req),
    .cfg_enable  (cfg_enable),
    .restart_busy(restart_busy)
);

// File: tb/sim_wdg_top.sv
module sim_wdg_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic       ctl_enable = 1'b0;
    logic [2:0] ctl_sel = 3'd0;
    logic       ctl_irq_en = 1'b0;
    logic       ctl_wake_en = 1'b0;
    logic       ctl_restart = 1'b0;
    logic       ctl_clr_tof = 1'b0;
    logic       ctl_clr_rstf = 1'b0;
    logic       pwr_down = 1'b0;
    logic       cfg_enable;
    logic [2:0] cfg_sel;
    logic       cfg_irq_en;
    logic       cfg_wake_en;
    logic       restart_busy;
    logic       tof_flag;
    logic       rstf_flag;
    logic       irq;
    logic       cpu_rst;
    logic       wake_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdg_top u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_sel(ctl_sel), .ctl_irq_en(ctl_irq_en), .ctl_wake_en(ctl_wake_en),
        .ctl_restart(ctl_restart), .ctl_clr_tof(ctl_clr_tof),
        .ctl_clr_rstf(ctl_clr_rstf), .pwr_down(pwr_down),
        .cfg_enable(cfg_enable), .cfg_sel(cfg_sel), .cfg_irq_en(cfg_irq_en),
        .cfg_wake_en(cfg_wake_en), .restart_busy(restart_busy),
        .tof_flag(tof_flag), .rstf_flag(rstf_flag), .irq(irq),
        .cpu_rst(cpu_rst), .wake_req(wake_req)
    );

    function automatic int lim(input int s);
        return 1 << (4 + 2 * s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input int n, inout int hits);
        repeat (n) begin
            @(negedge clk);
            if (cpu_rst) hits++;
        end
    endtask

    task automatic wr(input logic en, input int s, input logic ie, input logic wk,
                      input logic rs, input logic ct, input logic cr);
        ctl_we = 1'b1; ctl_enable = en; ctl_sel = 3'(s); ctl_irq_en = ie;
        ctl_wake_en = wk; ctl_restart = rs; ctl_clr_tof = ct; ctl_clr_rstf = cr;
        @(negedge clk);
        ctl_we = 1'b0; ctl_restart = 1'b0; ctl_clr_tof = 1'b0; ctl_clr_rstf = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired R1 act=0 exp=1");
        finish_run();
    end

    initial begin
        int s, ie, d, hits, n;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 tof", tof_flag, 0);
        chk("R1 rstf", rstf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cpu_rst", cpu_rst, 0);
        chk("R1 wake", wake_req, 0);
        chk("R1 enable", cfg_enable, 0);
        chk("R1 busy", restart_busy, 0);

        // R12 disabled counter does not time out
        step(300);
        chk("R12 tof idle", tof_flag, 0);

        // R2 / R3 / R4 with random intervals
        for (int i = 0; i < 5; i++) begin
            s  = (i == 0) ? 0 : int'($urandom % 5);
            ie = int'($urandom % 2);
            wr(1'b1, s, 1'(ie), 1'b0, 1'b0, 1'b0, 1'b0);
            step(lim(s) - 1);
            chk("R2 before interval", tof_flag, 0);
            step(1);
            chk("R2 at interval", tof_flag, 1);
            chk("R3 irq follows enable", irq, ie);
            step(3);
            chk("R4 tof held", tof_flag, 1);
            wr(1'b0, s, 1'(ie), 1'b0, 1'b0, 1'b1, 1'b0);
            chk("R4 tof cleared", tof_flag, 0);
            chk("R3 irq low", irq, 0);
        end

        // R5 / R6 restart inside the grace window
        for (int i = 0; i < 3; i++) begin
            s = 3 + int'($urandom % 2);
            wr(1'b1, s, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            step(lim(s));
            chk("R2 tof before restart", tof_flag, 1);
            d = 10 + int'($urandom % 800);
            step(d);
            wr(1'b1, s, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            chk("R5 busy set", restart_busy, 1);
            step(1);
            chk("R5 busy one clock", restart_busy, 0);
            hits = 0;
            watch(lim(s) - 1, hits);
            chk("R5 no early timeout", tof_flag, 0);
            step(1);
            chk("R5 next timeout", tof_flag, 1);
            chk("R6 no reset after restart", hits, 0);
            wr(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        end

        // R7 / R8 / R9 window expiry and reset pulse
        wr(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(16);
        chk("R2 tof sel0", tof_flag, 1);
        hits = 0;
        watch(1023, hits);
        chk("R7 no reset inside window", hits, 0);
        step(1);
        chk("R7 reset after window", cpu_rst, 1);
        chk("R8 cause flag", rstf_flag, 1);
        n = 1;
        while (cpu_rst && n < 200) begin
            step(1);
            if (cpu_rst) n++;
        end
        chk("R8 pulse length", n, 63);
        chk("R9 enable dropped", cfg_enable, 0);
        step(50);
        chk("R4 cause flag sticky", rstf_flag, 1);
        wr(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R4 cause flag cleared", rstf_flag, 0);
        step(100);
        chk("R9 counter stopped", tof_flag, 0);

        // R10 wakeup path
        pwr_down = 1'b1;
        wr(1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(16);
        chk("R2 tof wake run", tof_flag, 1);
        hits = 0;
        watch(1024, hits);
        chk("R10 wake raised", wake_req, 1);
        watch(200, hits);
        chk("R10 wake held", wake_req, 1);
        chk("R10 no reset", hits, 0);
        chk("R10 no cause flag", rstf_flag, 0);
        pwr_down = 1'b0;
        wr(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R10 wake dropped", wake_req, 0);
        hits = 0;
        watch(1200, hits);
        chk("R10 no later reset", hits, 0);

        // R11 select change cancels window
        wr(1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(16);
        step(500);
        wr(1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        hits = 0;
        watch(1000, hits);
        chk("R11 sel change cancels", hits, 0);
        wr(1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R11 disable cancels window
        wr(1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(316);
        chk("R2 tof before disable", tof_flag, 1);
        wr(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hits = 0;
        watch(1200, hits);
        chk("R11 disable cancels", hits, 0);
        chk("R4 tof kept while off", tof_flag, 1);

        finish_run();
    end

endmodule